// File: doc/BRIEF.md
# First-Level Translation Walk Unit

This block turns a 32-bit virtual address into the address of its first-level translation descriptor, fetches that one 32-bit word through a single-outstanding read port, and classifies it. There are two table bases. A 3-bit split value N chooses between them. When N is 0, every lookup goes through base 0. When N is greater than 0, base 0 serves only virtual addresses whose top N bits are all zero, and base 1 serves the rest. The table behind base 0 shrinks as N grows: it is 16 KB at N=0, 4 KB at N=2 (covering 1 GB) and 256 bytes at N=6 (covering 64 MB). Both its alignment and its index width follow N.

Each descriptor covers 1 MB of virtual space. A section descriptor yields a physical address directly. A table-pointer descriptor yields the base of a second-level table. Any other encoding is reported as a fault. Software loads both bases and N through a small write port, and that port is locked while a walk is in flight.

Top module: `l1_walk_unit`

## Requirements
- R1: After reset, N is 0, `req_ready` is 1, and `res_valid` and `mem_rd_req` are 0.
- R2: With N=0, every walk reads from `{base0[31:14], va[31:20], 2'b00}`, and `res_base1` is 0.
- R3: With N>0 and va[31:32-N] all zero, the walk reads from `{base0[31:14-N], va[31-N:20], 2'b00}` and reports `res_base1`=0.
- R4: With N>0 and any of va[31:32-N] set, the walk reads from `{base1[31:14], va[31:20], 2'b00}` and reports `res_base1`=1.
- R5: An accepted request (`req_valid` high while `req_ready` is high) produces exactly one single-cycle `mem_rd_req` pulse in the next cycle, and `req_ready` stays low until the result is produced.
- R6: `res_valid` is a single-cycle pulse in the cycle after the clock edge that samples `mem_rd_valid` high.
- R7: Descriptor bits [1:0]=2'b10 (section) give `res_kind`=2'b10, `res_fault`=0 and `res_addr`=`{desc[31:20], va[19:0]}`.
- R8: Descriptor bits [1:0]=2'b01 (table pointer) give `res_kind`=2'b01, `res_fault`=0 and `res_addr`=`{desc[31:10], 10'b0}`.
- R9: Descriptor bits [1:0] of 2'b00 or 2'b11 give `res_kind`=2'b00, `res_fault`=1 and `res_addr`=0.
- R10: Configuration writes issued while a walk is in progress (`req_ready` low) have no effect.
- R11: `cfg_sel` selects the register written: 2'b00 writes base 0, 2'b01 writes base 1, 2'b10 writes N from `cfg_wdata[2:0]`, and 2'b11 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Unit idle, request accepted |
| req_va | input | 32 | Virtual address to walk |
| mem_rd_req | output | 1 | Descriptor read pulse |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | 00 fault, 01 table pointer, 10 section |
| res_addr | output | 32 | Physical address or next-table base |
| res_fault | output | 1 | Descriptor was a fault |
| res_base1 | output | 1 | Walk used base 1 |

## Verification
The read pulse and its address appear in the cycle after the request is accepted. The result appears in the cycle after read data is returned, and it lasts one cycle. The bench drives inputs on falling edges and samples on the next falling edge. This makes each check land exactly one rising edge after its stimulus. A check that `mem_rd_req` and `res_valid` are low during the memory wait, and again after the pulse, confirms that both pulses are single-cycle. The bench varies the memory latency so that the result timing is tied to the data return and not to a fixed count.

// File: rtl/l1_walk_unit.sv
module l1_walk_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        res_valid,
  output logic [1:0]  res_kind,
  output logic [31:0] res_addr,
  output logic        res_fault,
  output logic        res_base1
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  localparam logic [1:0] K_FAULT = 2'b00, K_TABLE = 2'b01, K_SECT = 2'b10;

  st_t         st;
  logic [31:0] base0, base1, va_q;
  logic [2:0]  split;
  logic        use0;
  logic [31:0] top_mask, addr0, addr1, idx0;
  logic [1:0]  dk;
  logic [31:0] da;

  assign top_mask = ~(32'hFFFF_FFFF >> split);
  assign use0     = (req_va & top_mask) == 32'd0;
  assign idx0     = (req_va >> 20) & (32'h0000_0FFF >> split);
  assign addr0    = (base0 & ~(32'h0000_3FFF >> split)) | (idx0 << 2);
  assign addr1    = {base1[31:14], req_va[31:20], 2'b00};

  assign req_ready  = (st == S_IDLE);
  assign mem_rd_req = (st == S_REQ);
  assign res_fault  = (res_kind == K_FAULT);

  always_comb begin
    case (mem_rd_data[1:0])
      2'b01:   begin dk = K_TABLE; da = {mem_rd_data[31:10], 10'b0}; end
      2'b10:   begin dk = K_SECT;  da = {mem_rd_data[31:20], va_q[19:0]}; end
      default: begin dk = K_FAULT; da = 32'd0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base0 <= '0;
      base1 <= '0;
      split <= '0;
      va_q <= '0;
      mem_rd_addr <= '0;
      res_valid <= 1'b0;
      res_kind <= K_FAULT;
      res_addr <= '0;
      res_base1 <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (cfg_we && st == S_IDLE) begin
        case (cfg_sel)
          2'b00:   base0 <= cfg_wdata;
          2'b01:   base1 <= cfg_wdata;
          2'b10:   split <= cfg_wdata[2:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (req_valid) begin
          va_q        <= req_va;
          mem_rd_addr <= use0 ? addr0 : addr1;
          res_base1   <= ~use0;
          st          <= S_REQ;
        end
        S_REQ:  st <= S_WAIT;
        S_WAIT: if (mem_rd_valid) begin
          res_valid <= 1'b1;
          res_kind  <= dk;
          res_addr  <= da;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_READ:   assert property (@(posedge clk) disable iff (!rst_n) mem_rd_req |=> !mem_rd_req); // R5
  AST_BUSY_READ:  assert property (@(posedge clk) disable iff (!rst_n) mem_rd_req |-> !req_ready); // R5
  AST_RES_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R6
  AST_RES_AFTER:  assert property (@(posedge clk) disable iff (!rst_n) $rose(res_valid) |-> $past(mem_rd_valid)); // R6
  AST_N0_BASE0:   assert property (@(posedge clk) disable iff (!rst_n) (res_valid && split == 3'd0) |-> !res_base1); // R2
  AST_SECT_OFS:   assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_kind == K_SECT) |-> res_addr[19:0] == va_q[19:0]); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !req_ready |=> ($stable(base0) && $stable(base1) && $stable(split))); // R10
endmodule

// File: tb/l1_walk_unit_tb.sv
module l1_walk_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0; logic req_ready; logic [31:0] req_va = 0;
  logic mem_rd_req; logic [31:0] mem_rd_addr;
  logic mem_rd_valid = 0; logic [31:0] mem_rd_data = 0;
  logic res_valid; logic [1:0] res_kind; logic [31:0] res_addr; logic res_fault, res_base1;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [31:0] b0, b1; logic [2:0] n;

  always #4 clk = ~clk;

  l1_walk_unit dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] va, output logic sel1);
    logic hit0;
    hit0 = 1'b1;
    for (int i = 0; i < 8; i++) if (i < n && va[31-i]) hit0 = 1'b0;
    sel1 = !hit0;
    if (hit0) exp_addr = (b0 & (32'hFFFF_FFFF << (14 - n))) | (((va << n) >> (n + 20)) << 2);
    else      exp_addr = (b1 & 32'hFFFF_C000) | ((va >> 20) << 2);
  endfunction

  task automatic walk(input string req, input logic [31:0] va, input logic [31:0] desc,
                      input int lat, input bit busy_wr);
    logic s1; logic [31:0] ea, xa; logic [1:0] xk;
    ea = exp_addr(va, s1);
    case (desc[1:0])
      2'b10:   begin xk = 2'b10; xa = {desc[31:20], va[19:0]}; end
      2'b01:   begin xk = 2'b01; xa = {desc[31:10], 10'b0}; end
      default: begin xk = 2'b00; xa = 0; end
    endcase
    @(negedge clk); req_valid = 1; req_va = va;
    chk("R5 ready", req_ready, 1);
    @(negedge clk); req_valid = 0;
    chk("R5 read pulse", mem_rd_req, 1);
    chk({req, " addr"}, mem_rd_addr, ea);
    chk("R5 busy", req_ready, 0);
    for (int i = 0; i < lat; i++) begin
      if (busy_wr && i == 0) begin cfg_we = 1; cfg_sel = 2'b00; cfg_wdata = 32'hFFFF_FFFF; end
      if (busy_wr && i == 1) begin cfg_sel = 2'b01; end
      if (busy_wr && i == 2) begin cfg_sel = 2'b10; cfg_wdata = 32'h5; end
      @(negedge clk);
      cfg_we = 0;
      chk("R5 single read", mem_rd_req, 0);
      chk("R6 no early result", res_valid, 0);
    end
    mem_rd_valid = 1; mem_rd_data = desc;
    @(negedge clk); mem_rd_valid = 0;
    chk("R6 result", res_valid, 1);
    chk({req, " base sel"}, res_base1, s1);
    chk({req, " kind"}, res_kind, xk);
    chk({req, " res addr"}, res_addr, xa);
    chk({req, " fault"}, res_fault, xk == 2'b00);
    @(negedge clk);
    chk("R6 one cycle", res_valid, 0);
    chk("R5 ready again", req_ready, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 no result", res_valid, 0);
    chk("R1 no read", mem_rd_req, 0);
    rst_n = 1;
    b0 = 32'h8765_4321; b1 = 32'h1234_FFFF; n = 0;
    cfg(2'b00, b0); cfg(2'b01, b1);
    walk("R2 N0 high va R7", 32'hFFF1_2345, 32'hABC0_0C02, 1, 0);
    walk("R2 N0 low va R8", 32'h0010_0000, 32'h1357_9C01, 3, 0);
    cfg(2'b11, 32'h7);
    walk("R11 sel3 no write R9", 32'hC000_0000, 32'h0000_0000, 2, 0);
    n = 2; cfg(2'b10, 32'hFFFF_FFFA);
    walk("R3 N2 base0 R7", 32'h3FF5_5555, 32'h8000_0002, 1, 0);
    walk("R4 N2 base1 R9", 32'h4000_0000, 32'h0000_0003, 2, 0);
    n = 6; cfg(2'b10, 32'h6);
    walk("R3 N6 base0 R8", 32'h03F0_0001, 32'hFFFF_FFFD, 1, 0);
    walk("R4 N6 base1", 32'h0400_0000, 32'h0120_0002, 4, 0);
    n = 7; cfg(2'b10, 32'h7);
    walk("R3 N7 base0", 32'h01F0_ABCD, 32'h0000_0002, 1, 0);
    walk("R4 N7 base1", 32'h0200_0000, 32'h0000_0001, 1, 0);
    walk("R10 busy writes", 32'h0000_0000, 32'h0000_0002, 4, 0 == 1 ? 0 : 1);
    walk("R10 config kept", 32'h01F0_0000, 32'h0000_0002, 1, 0);
    walk("R10 base1 kept", 32'hF000_0000, 32'h0000_0002, 1, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule